// File: doc/BRIEF.md
# Mode-Aware Clock Loss Supervisor

This block runs on a free-running internal reference oscillator clock and watches two other clocks, the main clock and the sub clock. Each watched clock reaches the block as a toggle signal, one that flips once per period or per fixed number of periods. Each toggle passes through a two-flop synchroniser. A clock is declared lost when no toggle edge is seen for `LOSS_WIN` consecutive reference cycles while its supervisor is active. Lost flags are sticky until reset.

The supervisors follow the power mode. The main supervisor only works in main mode. Both supervisors are switched off in stop mode, and so is the reference oscillator enable. Leaving stop restores each one to the enable state held in the control word. After it is switched back on, each supervisor stays blind for a parameterised blanking period counted in reference cycles. This period is `MAIN_BLANK` on any entry to main mode and `SUB_BLANK` on any exit from stop.

A sub clock found dead is acted on when sub mode is next entered. A policy bit chooses what happens. Either a one-cycle reset request is issued, or the reference clock is selected as the sub-clock source. On single-clock builds a further bit selects the reference clock as the sub clock on every sub-mode entry.

Top module: `clk_loss_supervisor`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `mainLost`, `subLost`, `resetReq` and `subSelRef` are 0.
- R2: An active supervisor sets its lost flag once `LOSS_WIN` consecutive reference cycles pass with no synchronised toggle edge. The flag then stays at 1 until reset.
- R3: The main supervisor is active only when `modeIn` is 0 (main). `modeIn` 1 is sub, and 2 or 3 is stop. The main supervisor also needs `ctrlWord[1]` (main enable) and `ctrlWord[0]` (reference oscillator enable) to be 1.
- R4: The sub supervisor is active only when `ctrlWord[2]` (sub enable) and `ctrlWord[0]` are both 1 and the mode is not stop.
- R5: `refOscOn` equals `ctrlWord[0]` outside stop mode and is 0 in stop mode. It returns in the same cycle that stop mode is left.
- R6: On any change of `modeIn` into main mode, the main supervisor stays inactive for that cycle and the next `MAIN_BLANK` cycles.
- R7: On any change of `modeIn` out of stop mode, the sub supervisor stays inactive for that cycle and the next `SUB_BLANK` cycles.
- R8: On entry to sub mode with `subLost` at 1 and `ctrlWord[3]` (reset policy) at 1, `resetReq` is 1 for exactly one cycle, on the clock edge after the entry.
- R9: On entry to sub mode with `subLost` at 1 and `ctrlWord[3]` at 0, no reset request is issued and `subSelRef` becomes 1.
- R10: With `SINGLE_CLK`=1, entry to sub mode with `ctrlWord[4]` (substitute) at 1 and `ctrlWord[3]` at 0 sets `subSelRef` to 1 even without a loss. If `ctrlWord[3]` is 1, `subSelRef` becomes 0.
- R11: `subSelRef` changes only on the edge after an entry into sub mode, or after an entry into main mode, where it becomes 0.
- R12: A watched clock that keeps toggling at intervals shorter than `LOSS_WIN` cycles never raises its lost flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference oscillator clock, timebase of the block |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWord | input | 5 | Control word: [0] ref osc enable, [1] main enable, [2] sub enable, [3] reset policy, [4] substitute |
| modeIn | input | 2 | Power mode: 0 main, 1 sub, 2 or 3 stop |
| mainTgl | input | 1 | Toggle signal from the main clock (asynchronous) |
| subTgl | input | 1 | Toggle signal from the sub clock (asynchronous) |
| refOscOn | output | 1 | Effective reference oscillator enable |
| mainLost | output | 1 | Sticky main clock loss flag |
| subLost | output | 1 | Sticky sub clock loss flag |
| resetReq | output | 1 | One-cycle reset request |
| subSelRef | output | 1 | Selects the reference clock as the sub clock |

## Verification
A toggle input change reaches edge detection three reference edges later, through two synchroniser flops and one history flop. A lost flag then rises on the `LOSS_WIN`-th consecutive quiet active edge. `resetReq` and `subSelRef` are registered one edge after the mode change that triggers them. `refOscOn` follows `modeIn` within the same cycle. The bench holds a behavioural model that steps on every rising edge with the same delays, and compares all outputs on each falling edge. Directed checks are placed at points chosen well inside or after the blanking and loss windows, so that they do not rest on a single edge.

// File: rtl/clksup_pkg.sv
package clksup_pkg;

  localparam int CH_MAIN = 0;
  localparam int CH_SUB  = 1;
  localparam int NUM_CH  = 2;

  localparam int CW_REF_EN  = 0;
  localparam int CW_MAIN_EN = 1;
  localparam int CW_SUB_EN  = 2;
  localparam int CW_RST_POL = 3;
  localparam int CW_SUBST   = 4;
  localparam int CW_WIDTH   = 5;

  typedef enum logic [1:0] {
    CLS_MAIN = 2'd0,
    CLS_SUB  = 2'd1,
    CLS_STOP = 2'd2
  } modeCls_e;

  typedef struct packed {
    logic [NUM_CH-1:0] watchOn;
  } supStrobe_t;

  function automatic modeCls_e decodeMode(input logic [1:0] code);
    if (code[1])          return CLS_STOP;
    else if (code[0])     return CLS_SUB;
    else                  return CLS_MAIN;
  endfunction

endpackage

// File: rtl/clksup_sync.sv
module clksup_sync (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic stage1;
  logic stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;
endmodule

// File: rtl/clksup_blank.sv
module clksup_blank #(
  parameter int LEN = 4096
) (
  input  logic clk,
  input  logic rstN,
  input  logic arm,
  output logic quiet
);
  localparam int BW = $clog2(LEN + 1);

  logic [BW-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               remain <= '0;
    else if (arm)            remain <= BW'(LEN);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign quiet = (remain == '0) && !arm;
endmodule

// File: rtl/clksup_watch.sv
module clksup_watch
  import clksup_pkg::*;
#(
  parameter int LOSS_WIN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] tglIn,
  input  supStrobe_t        stb,
  output logic [NUM_CH-1:0] lost
);
  localparam int IW = (LOSS_WIN > 2) ? $clog2(LOSS_WIN) : 1;
  localparam logic [IW-1:0] IDLE_LAST = IW'(LOSS_WIN - 1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic          syncTgl;
    logic          prevTgl;
    logic          edgeSeen;
    logic [IW-1:0] idleCnt;
    logic          lostFlag;

    clksup_sync u_sync (
      .clk    (clk),
      .rstN   (rstN),
      .asyncIn(tglIn[ch]),
      .syncOut(syncTgl)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevTgl <= 1'b0;
      else       prevTgl <= syncTgl;
    end

    assign edgeSeen = syncTgl ^ prevTgl;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idleCnt  <= '0;
        lostFlag <= 1'b0;
      end else if (!stb.watchOn[ch] || edgeSeen) begin
        idleCnt  <= '0;
      end else if (idleCnt == IDLE_LAST) begin
        lostFlag <= 1'b1;
      end else begin
        idleCnt  <= idleCnt + 1'b1;
      end
    end

    assign lost[ch] = lostFlag;
  end
endmodule

// File: rtl/clksup_ctrl.sv
module clksup_ctrl
  import clksup_pkg::*;
#(
  parameter int MAIN_BLANK = 4096,
  parameter int SUB_BLANK  = 262144,
  parameter bit SINGLE_CLK = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CW_WIDTH-1:0] ctrlWord,
  input  logic [1:0]          modeIn,
  input  logic [NUM_CH-1:0]   lostIn,
  output supStrobe_t          stb,
  output logic                refOscOn,
  output logic                resetReq,
  output logic                subSelRef
);
  modeCls_e curCls;
  modeCls_e prevCls;
  logic     enterMain;
  logic     enterSub;
  logic     leaveStop;
  logic     mainQuiet;
  logic     subQuiet;
  logic     substAllowed;
  logic     selNext;

  assign curCls    = decodeMode(modeIn);
  assign enterMain = (curCls == CLS_MAIN) && (prevCls != CLS_MAIN);
  assign enterSub  = (curCls == CLS_SUB)  && (prevCls != CLS_SUB);
  assign leaveStop = (curCls != CLS_STOP) && (prevCls == CLS_STOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevCls <= CLS_MAIN;
    else       prevCls <= curCls;
  end

  clksup_blank #(.LEN(MAIN_BLANK)) u_mainBlank (
    .clk  (clk),
    .rstN (rstN),
    .arm  (enterMain),
    .quiet(mainQuiet)
  );

  clksup_blank #(.LEN(SUB_BLANK)) u_subBlank (
    .clk  (clk),
    .rstN (rstN),
    .arm  (leaveStop),
    .quiet(subQuiet)
  );

  assign refOscOn = ctrlWord[CW_REF_EN] && (curCls != CLS_STOP);

  assign stb.watchOn[CH_MAIN] = ctrlWord[CW_MAIN_EN] && refOscOn &&
                                (curCls == CLS_MAIN) && mainQuiet;
  assign stb.watchOn[CH_SUB]  = ctrlWord[CW_SUB_EN] && refOscOn && subQuiet;

  if (SINGLE_CLK) begin : g_single
    assign substAllowed = ctrlWord[CW_SUBST];
  end else begin : g_dual
    logic unusedSubst;
    assign unusedSubst  = ctrlWord[CW_SUBST];
    assign substAllowed = 1'b0;
  end

  assign selNext = !ctrlWord[CW_RST_POL] && (lostIn[CH_SUB] || substAllowed);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetReq  <= 1'b0;
      subSelRef <= 1'b0;
    end else begin
      resetReq <= enterSub && lostIn[CH_SUB] && ctrlWord[CW_RST_POL];
      if (enterSub)       subSelRef <= selNext;
      else if (enterMain) subSelRef <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_loss_supervisor.sv
module clk_loss_supervisor
  import clksup_pkg::*;
#(
  parameter int LOSS_WIN   = 64,
  parameter int MAIN_BLANK = 4096,
  parameter int SUB_BLANK  = 262144,
  parameter bit SINGLE_CLK = 1'b1
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic [4:0] ctrlWord,
  input  logic [1:0] modeIn,
  input  logic       mainTgl,
  input  logic       subTgl,
  output logic       refOscOn,
  output logic       mainLost,
  output logic       subLost,
  output logic       resetReq,
  output logic       subSelRef
);
  supStrobe_t        ctlStb;
  logic [NUM_CH-1:0] lostVec;
  logic [NUM_CH-1:0] watchOnVec;
  logic [NUM_CH-1:0] tglVec;

  assign tglVec[CH_MAIN] = mainTgl;
  assign tglVec[CH_SUB]  = subTgl;

  clksup_ctrl #(
    .MAIN_BLANK(MAIN_BLANK),
    .SUB_BLANK (SUB_BLANK),
    .SINGLE_CLK(SINGLE_CLK)
  ) u_ctrl (
    .clk      (refClk),
    .rstN     (rstN),
    .ctrlWord (ctrlWord),
    .modeIn   (modeIn),
    .lostIn   (lostVec),
    .stb      (ctlStb),
    .refOscOn (refOscOn),
    .resetReq (resetReq),
    .subSelRef(subSelRef)
  );

  clksup_watch #(.LOSS_WIN(LOSS_WIN)) u_watch (
    .clk  (refClk),
    .rstN (rstN),
    .tglIn(tglVec),
    .stb  (ctlStb),
    .lost (lostVec)
  );

  assign watchOnVec = ctlStb.watchOn;
  assign mainLost   = lostVec[CH_MAIN];
  assign subLost    = lostVec[CH_SUB];
endmodule

// File: rtl/clksup_checker.sv
module clksup_checker (
  input logic       clk,
  input logic       rstN,
  input logic [4:0] ctrlWord,
  input logic [1:0] modeIn,
  input logic [1:0] watchOn,
  input logic       refOscOn,
  input logic       mainLost,
  input logic       subLost,
  input logic       resetReq,
  input logic       subSelRef
);
  assert_mainLostSticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    mainLost |=> mainLost);

  assert_subLostSticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    subLost |=> subLost);

  assert_mainOffOutsideMain_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn != 2'd0) |-> !watchOn[0]);

  assert_subNeedsRef_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWord[0] |-> !watchOn[1]);

  assert_refOffInStop_R5: assert property (@(posedge clk) disable iff (!rstN)
    modeIn[1] |-> !refOscOn);

  assert_resetSingle_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  assert_resetNeedsLoss_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(subLost));

  assert_selOnEntry_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(subSelRef) |-> ($past(modeIn) == 2'd1 || $past(modeIn) == 2'd0));
endmodule

bind clk_loss_supervisor clksup_checker u_chk (
  .clk      (refClk),
  .rstN     (rstN),
  .ctrlWord (ctrlWord),
  .modeIn   (modeIn),
  .watchOn  (watchOnVec),
  .refOscOn (refOscOn),
  .mainLost (mainLost),
  .subLost  (subLost),
  .resetReq (resetReq),
  .subSelRef(subSelRef)
);

// File: tb/clk_loss_supervisor_test.sv
`timescale 1ns/1ps
module clk_loss_supervisor_test;
  localparam int LW = 8;
  localparam int MB = 20;
  localparam int SB = 40;
  localparam int WATCHDOG = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] ctrlWord = '0;
  logic [1:0] modeIn = 2'd0;
  logic       mainTgl = 1'b0;
  logic       subTgl = 1'b0;
  logic       mainRun = 1'b0;
  logic       subRun = 1'b0;
  logic       refOscOn, mainLost, subLost, resetReq, subSelRef;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  clk_loss_supervisor #(
    .LOSS_WIN(LW), .MAIN_BLANK(MB), .SUB_BLANK(SB), .SINGLE_CLK(1'b1)
  ) uut (
    .refClk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .modeIn(modeIn),
    .mainTgl(mainTgl), .subTgl(subTgl), .refOscOn(refOscOn),
    .mainLost(mainLost), .subLost(subLost), .resetReq(resetReq),
    .subSelRef(subSelRef)
  );

  // toggle sources: flip every third reference cycle while running
  int tglDiv = 0;
  always @(posedge clk) begin
    #1;
    tglDiv = (tglDiv + 1) % 3;
    if (tglDiv == 0) begin
      if (mainRun) mainTgl = ~mainTgl;
      if (subRun)  subTgl  = ~subTgl;
    end
  end

  // behavioural reference model
  int s1[2], s2[2], pv[2], idle[2], lostM[2];
  int prevCls, mBlank, sBlank, rqM, selM;

  function automatic int cls(input logic [1:0] m);
    return m[1] ? 2 : (m[0] ? 1 : 0);
  endfunction

  always @(posedge clk) begin
    int c, nLost[2], nIdle[2], act[2], tg[2];
    bit evMain, evSub, evStop, refOn;
    cycles++;
    if (!rstN) begin
      for (int k = 0; k < 2; k++) begin
        s1[k] = 0; s2[k] = 0; pv[k] = 0; idle[k] = 0; lostM[k] = 0;
      end
      prevCls = 0; mBlank = 0; sBlank = 0; rqM = 0; selM = 0;
    end else begin
      c = cls(modeIn);
      evMain = (c == 0) && (prevCls != 0);
      evSub  = (c == 1) && (prevCls != 1);
      evStop = (c != 2) && (prevCls == 2);
      refOn  = ctrlWord[0] && (c != 2);
      act[0] = ctrlWord[1] && refOn && (c == 0) && (mBlank == 0) && !evMain;
      act[1] = ctrlWord[2] && refOn && (sBlank == 0) && !evStop;
      tg[0] = mainTgl; tg[1] = subTgl;
      for (int k = 0; k < 2; k++) begin
        nIdle[k] = idle[k]; nLost[k] = lostM[k];
        if (!act[k] || (s2[k] != pv[k])) nIdle[k] = 0;
        else if (idle[k] == LW - 1) nLost[k] = 1;
        else nIdle[k] = idle[k] + 1;
      end
      rqM = evSub && lostM[1] && ctrlWord[3];
      if (evSub) selM = !ctrlWord[3] && (lostM[1] || ctrlWord[4]);
      else if (evMain) selM = 0;
      mBlank = evMain ? MB : (mBlank > 0 ? mBlank - 1 : 0);
      sBlank = evStop ? SB : (sBlank > 0 ? sBlank - 1 : 0);
      for (int k = 0; k < 2; k++) begin
        pv[k] = s2[k]; s2[k] = s1[k]; s1[k] = tg[k];
        idle[k] = nIdle[k]; lostM[k] = nLost[k];
      end
      prevCls = c;
    end
  end

  task automatic cmp(input string tag, input logic act, input int exp);
    checks++;
    if (act !== exp[0]) begin
      fails++;
      $display("FAIL %s (%s) t=%0t actual=%0b expected=%0d", tag, phase, $time, act, exp);
    end
  endtask

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      cmp("R2 mainLost", mainLost, lostM[0]);
      cmp("R4 subLost", subLost, lostM[1]);
      cmp("R8 resetReq", resetReq, rqM);
      cmp("R11 subSelRef", subSelRef, selM);
      cmp("R5 refOscOn", refOscOn, (ctrlWord[0] && !modeIn[1]) ? 1 : 0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doReset;
    rstN = 1'b0;
    step(2);
    checks++;
    if (mainLost !== 1'b0 || subLost !== 1'b0 || resetReq !== 1'b0 || subSelRef !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual=%b%b%b%b expected=0000",
               mainLost, subLost, resetReq, subSelRef);
    end
    rstN = 1'b1;
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog R1 flow actual=hung expected=done");
      summary();
    end
  end

  initial begin
    step(1);
    // R1: reset state
    phase = "R1";
    ctrlWord = 5'b00111; modeIn = 2'd0; mainRun = 1; subRun = 1;
    doReset();
    step(1);
    cmp("R1 post-reset resetReq", resetReq, 0);

    // R12: running clocks never flagged
    phase = "R12";
    step(100);
    cmp("R12 mainLost running", mainLost, 0);
    cmp("R12 subLost running", subLost, 0);

    // R2 / R9 / R11: dead sub clock, substitution policy
    phase = "R9";
    subRun = 0;
    step(30);
    cmp("R2 subLost set", subLost, 1);
    modeIn = 2'd1;
    step(2);
    cmp("R9 subSelRef set", subSelRef, 1);
    cmp("R9 no resetReq", resetReq, 0);
    step(10);
    cmp("R2 subLost sticky", subLost, 1);
    modeIn = 2'd0;
    step(2);
    cmp("R11 subSelRef cleared on main", subSelRef, 0);

    // R3 / R5 / R6 / R7
    phase = "R3";
    subRun = 1; mainRun = 1; ctrlWord = 5'b00111;
    doReset();
    modeIn = 2'd1; mainRun = 0;
    step(50);
    cmp("R3 main not watched in sub", mainLost, 0);
    phase = "R5";
    modeIn = 2'd2;
    step(1);
    cmp("R5 refOscOn off in stop", refOscOn, 0);
    subRun = 0;
    step(50);
    cmp("R3 main not watched in stop", mainLost, 0);
    cmp("R7 sub not watched in stop", subLost, 0);
    phase = "R6";
    modeIn = 2'd0;
    #1;
    cmp("R5 refOscOn back at exit", refOscOn, 1);
    step(15);
    cmp("R6 main blanked", mainLost, 0);
    step(30);
    cmp("R6 main lost after blank", mainLost, 1);
    phase = "R7";
    cmp("R7 sub still blanked", subLost, 0);
    step(20);
    cmp("R7 sub lost after blank", subLost, 1);

    // R8: reset policy
    phase = "R8";
    mainRun = 1; subRun = 1; modeIn = 2'd0; ctrlWord = 5'b01111;
    doReset();
    subRun = 0;
    step(30);
    cmp("R8 subLost before entry", subLost, 1);
    modeIn = 2'd1;
    step(1);
    cmp("R8 resetReq pulse", resetReq, 1);
    cmp("R8 subSelRef stays", subSelRef, 0);
    step(1);
    cmp("R8 resetReq single", resetReq, 0);

    // R10: substitution bit on a single-clock build
    phase = "R10";
    subRun = 1; modeIn = 2'd0; ctrlWord = 5'b10111;
    doReset();
    step(20);
    modeIn = 2'd1;
    step(2);
    cmp("R10 subst selects ref", subSelRef, 1);
    modeIn = 2'd0; ctrlWord = 5'b11111;
    step(3);
    modeIn = 2'd1;
    step(2);
    cmp("R10 policy blocks subst", subSelRef, 0);

    // R4: sub supervisor needs reference oscillator
    phase = "R4";
    modeIn = 2'd0; ctrlWord = 5'b00100; subRun = 0; mainRun = 0;
    doReset();
    step(40);
    cmp("R4 no sub watch w/o ref", subLost, 0);
    cmp("R3 no main watch when disabled", mainLost, 0);
    ctrlWord = 5'b00101;
    step(20);
    cmp("R4 sub watch with ref", subLost, 1);

    step(2);
    summary();
  end
endmodule